// File: doc/BRIEF.md
# Thirty-two pin GPIO bank with atomic set and clear

This block is the register front end of one bank of 32 general-purpose pins. It holds a direction register and an output latch, drives the output-enable and output-value lines of 32 tristate pads, and samples the pad levels through a two-stage synchronizer. Software reaches it over a simple 32-bit register bus with a byte address, a write strobe, write data and registered read data.

The output latch can be written in three ways. A full-word write replaces every bit. A mask written to the set port raises only the bits that are 1 in the mask. A mask written to the clear port lowers only the bits that are 1 in the mask. The set and clear ports let several drivers change their own pins without a read-modify-write race. The synchronized pad vector is also exported on its own port, so a separate interrupt block can detect edges without a second synchronizer.

Top module: `gpio_setclr_bank`

## Requirements
- R1: After reset every pin is an input, so `pad_oe` is all zeros. The output latch and `pad_out` are zero, and a read of word offset 0x00 returns 0xFFFFFFFF.
- R2: A write to word offset 0x00 (direction) stores the data. A stored 1 makes a pin an input and a stored 0 makes it an output, so `pad_oe` is the inverse of the direction word from the clock edge of the write onward.
- R3: A write to offset 0x04 replaces the whole output latch, and `pad_out` always equals the latch.
- R4: A write to offset 0x08 sets the latch bits that are 1 in the data and leaves the other bits unchanged.
- R5: A write to offset 0x0C clears the latch bits that are 1 in the data and leaves the other bits unchanged.
- R6: Reads of offsets 0x04, 0x08 and 0x0C all return the current output latch.
- R7: A read of offset 0x10 returns the synchronized pad level of every pin, including pins configured as outputs. A pad change made before clock edge k appears on `bus_rdata` after edge k+2 when that address is held, and not after edge k+1.
- R8: `pin_sync` shows a pad change after the second clock edge that follows it, and not after the first.
- R9: Writes to offset 0x10 and to any word offset from 0x14 upward change neither direction nor latch. Reads of offsets from 0x14 upward return zero.
- R10: `bus_rdata` is registered. It shows the value selected by `bus_addr` at a clock edge, after that edge. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 6 | Byte address; bits [5:2] select the word |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data or pin mask |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Raw pad input levels |
| pad_oe | output | 32 | Pad driver enable, 1 drives the pin |
| pad_out | output | 32 | Pad output value |
| pin_sync | output | 32 | Synchronized pad levels for the interrupt block |

## Verification
A corrupted direction bit or latch bit reaches `pad_oe` or `pad_out` in the same cycle and shows up on the next read one edge later. A set or clear port that touches bits outside its mask shows up as a wrong neighbouring pin. A synchronizer that is one stage too short or too long shows up as a level that arrives one edge early or late, both on `pin_sync` and on a held input-data read. A decoder that aliases the upper offsets shows up as nonzero reads there, or as latch and direction values changed by writes that should be ignored.

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank #(
  parameter int PINS = 32,
  parameter int AW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [PINS-1:0] bus_wdata,
  output logic [PINS-1:0] bus_rdata,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pin_sync
);
  localparam int WA = AW - 2;
  localparam logic [WA-1:0] OFS_DIR = WA'(0);
  localparam logic [WA-1:0] OFS_OUT = WA'(1);
  localparam logic [WA-1:0] OFS_SET = WA'(2);
  localparam logic [WA-1:0] OFS_CLR = WA'(3);
  localparam logic [WA-1:0] OFS_IN  = WA'(4);

  logic [WA-1:0]   widx;
  logic [PINS-1:0] dir_q, lat_q, sy1_q, sy2_q, rd_d;

  assign widx     = bus_addr[AW-1:2];
  assign pad_oe   = ~dir_q;
  assign pad_out  = lat_q;
  assign pin_sync = sy2_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          dir_q <= '1;
    else if (bus_we && widx == OFS_DIR)  dir_q <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lat_q <= '0;
    else if (bus_we)
      case (widx)
        OFS_OUT: lat_q <= bus_wdata;
        OFS_SET: lat_q <= lat_q | bus_wdata;
        OFS_CLR: lat_q <= lat_q & ~bus_wdata;
        default: lat_q <= lat_q;
      endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1_q <= '0;
      sy2_q <= '0;
    end else begin
      sy1_q <= pad_in;
      sy2_q <= sy1_q;
    end

  always_comb
    case (widx)
      OFS_DIR:                   rd_d = dir_q;
      OFS_OUT, OFS_SET, OFS_CLR: rd_d = lat_q;
      OFS_IN:                    rd_d = sy2_q;
      default:                   rd_d = '0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_d;
endmodule

// File: rtl/gpio_setclr_bank_chk.sv
module gpio_setclr_bank_chk #(
  parameter int PINS = 32,
  parameter int AW   = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_we,
  input logic [PINS-1:0] bus_wdata,
  input logic [PINS-1:0] bus_rdata,
  input logic [PINS-1:0] pad_in,
  input logic [PINS-1:0] pad_oe,
  input logic [PINS-1:0] pad_out,
  input logic [PINS-1:0] pin_sync
);
  logic [1:0] age;
  logic [AW-3:0] wi;
  assign wi = bus_addr[AW-1:2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;

  a_r2_oe_only_on_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && !($past(bus_we) && $past(wi) == 0)) |-> $stable(pad_oe));

  a_r3_full_write: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && $past(bus_we) && $past(wi) == 1) |-> pad_out == $past(bus_wdata));

  a_r4_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && $past(bus_we) && $past(wi) == 2) |->
      (pad_out == ($past(pad_out) | $past(bus_wdata))));

  a_r5_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && $past(bus_we) && $past(wi) == 3) |->
      (pad_out == ($past(pad_out) & ~$past(bus_wdata))));

  a_r9_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && $past(wi) >= 4) |-> ($stable(pad_out) && $stable(pad_oe)));

  a_r9_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && $past(wi) >= 5) |-> bus_rdata == '0);

  a_r8_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> pin_sync == $past(pad_in, 2));
endmodule

bind gpio_setclr_bank gpio_setclr_bank_chk #(.PINS(PINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
  .pad_oe(pad_oe), .pad_out(pad_out), .pin_sync(pin_sync)
);

// File: tb/test_gpio_setclr_bank.sv
module test_gpio_setclr_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_oe, pad_out, pin_sync;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  gpio_setclr_bank i_gpio_setclr_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pin_sync(pin_sync)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk); #1;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 pad_out", pad_out, 32'h0);
    rd(6'h00, v); chk("R1 dir read", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_dir;
    logic [31:0] v;
    wr(6'h00, 32'hFFFF_00F0);
    chk("R2 pad_oe", pad_oe, 32'h0000_FF0F);
    rd(6'h00, v); chk("R2 dir read", v, 32'hFFFF_00F0);
  endtask

  task automatic t_full;
    logic [31:0] v;
    wr(6'h04, 32'hA5A5_0F0F);
    chk("R3 pad_out", pad_out, 32'hA5A5_0F0F);
    wr(6'h04, 32'h1234_5678);
    chk("R3 replace", pad_out, 32'h1234_5678);
    rd(6'h05, v); chk("R10 low addr bits ignored", v, 32'h1234_5678);
  endtask

  task automatic t_set_clear;
    logic [31:0] v;
    wr(6'h04, 32'h0000_00F0);
    wr(6'h08, 32'h8000_0003);
    chk("R4 set", pad_out, 32'h8000_00F3);
    wr(6'h08, 32'h0);
    chk("R4 zero mask", pad_out, 32'h8000_00F3);
    wr(6'h0C, 32'h0000_0031);
    chk("R5 clear", pad_out, 32'h8000_00C2);
    wr(6'h0C, 32'h0);
    chk("R5 zero mask", pad_out, 32'h8000_00C2);
    rd(6'h08, v); chk("R6 set addr read", v, 32'h8000_00C2);
    rd(6'h0C, v); chk("R6 clear addr read", v, 32'h8000_00C2);
  endtask

  task automatic t_input;
    logic [31:0] v;
    @(negedge clk);
    bus_addr = 6'h10;
    pad_in = 32'hDEAD_BEEF;
    @(posedge clk); #1;
    chk("R8 sync after 1 edge", pin_sync, 32'h0);
    @(posedge clk); #1;
    chk("R8 sync after 2 edges", pin_sync, 32'hDEAD_BEEF);
    chk("R7 read after 2 edges", bus_rdata, 32'h0);
    @(posedge clk); #1;
    chk("R7 read after 3 edges", bus_rdata, 32'hDEAD_BEEF);
    wr(6'h00, 32'hFFFF_FFFE);
    wr(6'h04, 32'h0000_0001);
    @(negedge clk); pad_in = 32'h0000_0000;
    repeat (3) @(posedge clk);
    rd(6'h10, v); chk("R7 output pin reads pad", v, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr(6'h00, 32'h0F0F_0F0F);
    wr(6'h04, 32'h3333_3333);
    wr(6'h10, 32'hFFFF_FFFF);
    wr(6'h14, 32'h0);
    wr(6'h24, 32'hFFFF_FFFF);
    wr(6'h3C, 32'h0);
    chk("R9 latch kept", pad_out, 32'h3333_3333);
    chk("R9 dir kept", pad_oe, 32'hF0F0_F0F0);
    rd(6'h14, v); chk("R9 read 0x14", v, 32'h0);
    rd(6'h3C, v); chk("R9 read 0x3C", v, 32'h0);
    rd(6'h00, v); chk("R10 read after unmapped", v, 32'h0F0F_0F0F);
  endtask

  initial begin
    #(4 * 100000);
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_dir();
    t_full();
    t_set_clear();
    t_input();
    t_unmapped();
    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule